// File: doc/BRIEF.md
# Latched Second-Level Interrupt Controller

This block collects up to 32 interrupt sources, one bit each, and folds them into a single request line for a parent interrupt controller. Software sees it through a small word-addressed register window. It reads the pending sources there and controls a per-source mask. Mask bits are never written directly. One register sets mask bits and a second register clears them, so each is a write-1 action. A third register reads back the current mask.

A build-time parameter picks one of two variants. In the latched variant, each synchronized rising edge on a source sets a sticky status bit. Software clears that bit by writing 1 to a clear register. In the level variant, the status register shows the synchronized live input levels. That variant has no clear register, so a source can only be quieted where it originates. The two variants place their registers at different offsets. The request line is high whenever a status bit is set and the matching mask bit is clear.

Top module: `irq_l2_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every latched status bit reads 0, and `irq_o` is low.
- R2: A write of 1s to the mask-set register (offset 0x10 latched, 0x08 level) masks those sources. Mask bits written as 0 keep their value.
- R3: A write of 1s to the mask-clear register (offset 0x14 latched, 0x0C level) unmasks those sources. Mask bits written as 0 keep their value.
- R4: The mask-status register (offset 0x0C latched, 0x04 level) reads back the current mask, with bit n belonging to source n.
- R5: In the latched variant, a rising edge on a source sets status bit n at offset 0x00. The bit stays set after the source falls, and a source held high does not set it again.
- R6: In the latched variant, writing 1s to the clear register (offset 0x08) clears those status bits and leaves bits written as 0 untouched. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R7: In the level variant, status at offset 0x00 follows the synchronized input levels, and no register write can clear it.
- R8: Status reports pending sources whether or not they are masked.
- R9: `irq_o` is high exactly when some status bit is set and its mask bit is 0.
- R10: A read is registered. `rd_ack` and `rd_data` appear one cycle after `rd_valid`. Reads of mask-set, mask-clear, clear and unmapped offsets return 0.
- R11: Writes to status, to mask-status, or to unmapped offsets change nothing.
- R12: Each source passes through SYNC_STAGES flops. A latched status bit, and with it `irq_o`, rises SYNC_STAGES+1 clock edges after the source rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source inputs, asynchronous |
| bus_addr | input | ADDR_W | Byte offset; the low two bits are ignored |
| wr_valid | input | 1 | Single-cycle word write strobe |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request strobe |
| rd_data | output | DATA_W | Registered read data |
| rd_ack | output | 1 | Read data valid, one cycle after `rd_valid` |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The hardest case to reach is a clear write that lands in the exact cycle a new edge on the same source reaches the status register. The stimulus first leaves the bit set by an earlier pulse. It then raises the source at a falling clock edge, counts SYNC_STAGES rising edges, and presents the clear write for the following edge. The bench expects the bit to survive. It then repeats the clear with the source still high and expects the bit to go away, since a held level produces no new edge.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_CLEAR,
      SEL_MSTAT,
      SEL_MSET,
      SEL_MCLR
   } reg_sel_e;

   // Byte offset (low two bits already zero) to register, per variant.
   function automatic reg_sel_e decode_reg(input logic [7:0] off, input bit latched);
      reg_sel_e s;
      s = SEL_NONE;
      if (latched) begin
         case (off)
            8'h00:   s = SEL_STATUS;
            8'h08:   s = SEL_CLEAR;
            8'h0C:   s = SEL_MSTAT;
            8'h10:   s = SEL_MSET;
            8'h14:   s = SEL_MCLR;
            default: s = SEL_NONE;
         endcase
      end else begin
         case (off)
            8'h00:   s = SEL_STATUS;
            8'h04:   s = SEL_MSTAT;
            8'h08:   s = SEL_MSET;
            8'h0C:   s = SEL_MCLR;
            default: s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[i] <= '0;
               else        stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/l2irq_capture.sv
module l2irq_capture #(
   parameter int WIDTH   = 32,
   parameter bit LATCHED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] status_o
);
   generate
      if (LATCHED) begin : g_latched
         logic [WIDTH-1:0] prev_q;
         logic [WIDTH-1:0] stat_q;
         logic [WIDTH-1:0] rise;

         assign rise = lvl_i & ~prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
               stat_q <= '0;
            end else begin
               prev_q <= lvl_i;
               // a fresh edge outranks a clear in the same cycle
               stat_q <= (stat_q & ~clr_i) | rise;
            end
         end
         assign status_o = stat_q;
      end else begin : g_level
         logic level_unused;
         assign level_unused = ^{clr_i, clk, rst_n};
         assign status_o = lvl_i;
      end
   endgenerate
endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] bits_i,
   output logic [WIDTH-1:0] mask_o
);
   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '1;
      else if (set_en) mask_q <= mask_q | bits_i;
      else if (clr_en) mask_q <= mask_q & ~bits_i;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/irq_l2_ctrl.sv
module irq_l2_ctrl
   import l2irq_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LATCHED     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ack,
   output logic              irq_o
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must lie in 5..8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [7:0]         off8;
   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] sync_w;
   logic [NUM_SRC-1:0] clr_w;
   logic [NUM_SRC-1:0] status_w;
   logic [NUM_SRC-1:0] mask_w;
   logic [DATA_W-1:0]  rd_mux;
   logic [DATA_W-1:0]  rd_data_q;
   logic               rd_ack_q;

   assign off8  = 8'(bus_addr) & 8'hFC;
   assign sel   = decode_reg(off8, LATCHED);
   assign wbits = wr_data[NUM_SRC-1:0];
   assign clr_w = (wr_valid && sel == SEL_CLEAR) ? wbits : '0;

   l2irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (sync_w)
   );

   l2irq_capture #(.WIDTH(NUM_SRC), .LATCHED(LATCHED)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (sync_w),
      .clr_i    (clr_w),
      .status_o (status_w)
   );

   l2irq_mask #(.WIDTH(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_valid && sel == SEL_MSET),
      .clr_en (wr_valid && sel == SEL_MCLR),
      .bits_i (wbits),
      .mask_o (mask_w)
   );

   always_comb begin
      case (sel)
         SEL_STATUS: rd_mux = DATA_W'(status_w);
         SEL_MSTAT:  rd_mux = DATA_W'(mask_w);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q <= '0;
         rd_ack_q  <= 1'b0;
      end else begin
         rd_ack_q <= rd_valid;
         if (rd_valid) rd_data_q <= rd_mux;
      end
   end

   assign rd_data = rd_data_q;
   assign rd_ack  = rd_ack_q;
   assign irq_o   = |(status_w & ~mask_w);
endmodule

// File: rtl/l2irq_chk.sv
module l2irq_chk
   import l2irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter bit LATCHED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               wr_valid,
   input logic [NUM_SRC-1:0] wdata,
   input logic               rd_valid,
   input logic [DATA_W-1:0]  rd_data,
   input logic               rd_ack,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] status,
   input logic [NUM_SRC-1:0] mask
);
   reg_sel_e s;
   assign s = decode_reg(8'(bus_addr) & 8'hFC, LATCHED);

   p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && s == SEL_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

   p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && s == SEL_MCLR) |=> ((mask & $past(wdata)) == '0));

   p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (s == SEL_STATUS || s == SEL_MSTAT || s == SEL_NONE)) |=> $stable(mask));

   p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status != '0 && mask != '1));

   p_rd_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_ack);

   p_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_ack);

   p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (s == SEL_MSET || s == SEL_MCLR || s == SEL_CLEAR || s == SEL_NONE))
      |=> (rd_data == '0));

   generate
      if (LATCHED) begin : g_sticky
         p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_valid && s == SEL_CLEAR) |=> ((status & $past(status)) == $past(status)));
      end
   endgenerate
endmodule

bind irq_l2_ctrl l2irq_chk #(
   .NUM_SRC (NUM_SRC),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .LATCHED (LATCHED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .wr_valid (wr_valid),
   .wdata    (wr_data[NUM_SRC-1:0]),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .rd_ack   (rd_ack),
   .irq_o    (irq_o),
   .status   (status_w),
   .mask     (mask_w)
);

// File: tb/tb_irq_l2_ctrl.sv
`timescale 1ns/100ps
module tb_irq_l2_ctrl;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [7:0]  a_addr = '0, b_addr = '0;
   logic        a_wv = 1'b0, b_wv = 1'b0, a_rv = 1'b0, b_rv = 1'b0;
   logic [31:0] a_wd = '0, b_wd = '0;
   logic [31:0] a_rd, b_rd;
   logic        a_ack, b_ack, a_irq, b_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [31:0] qa_exp[$], qb_exp[$];
   string       qa_tag[$], qb_tag[$];

   always #2.5 clk = ~clk;

   irq_l2_ctrl #(.SYNC_STAGES(SYNC), .LATCHED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(a_addr), .wr_valid(a_wv),
      .wr_data(a_wd), .rd_valid(a_rv), .rd_data(a_rd), .rd_ack(a_ack), .irq_o(a_irq));

   irq_l2_ctrl #(.SYNC_STAGES(SYNC), .LATCHED(1'b0)) dut_lvl (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(b_addr), .wr_valid(b_wv),
      .wr_data(b_wd), .rd_valid(b_rv), .rd_data(b_rd), .rd_ack(b_ack), .irq_o(b_irq));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit lvl, input logic [7:0] addr, input logic [31:0] data);
      @(negedge clk);
      if (lvl) begin b_addr = addr; b_wd = data; b_wv = 1'b1; end
      else     begin a_addr = addr; a_wd = data; a_wv = 1'b1; end
      @(negedge clk);
      a_wv = 1'b0; b_wv = 1'b0;
   endtask

   // driver: pushes the expected read value into the scoreboard
   task automatic rd(input bit lvl, input logic [7:0] addr, input logic [31:0] exp, input string tag);
      @(negedge clk);
      if (lvl) begin b_addr = addr; b_rv = 1'b1; qb_exp.push_back(exp); qb_tag.push_back(tag); end
      else     begin a_addr = addr; a_rv = 1'b1; qa_exp.push_back(exp); qa_tag.push_back(tag); end
      @(negedge clk);
      a_rv = 1'b0; b_rv = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitors: pop and compare as read data returns
   always @(negedge clk) begin
      if (rst_n && a_ack) begin
         if (qa_exp.size() == 0) chk(1, 0, "R10 latched ack with no request");
         else chk(a_rd, qa_exp.pop_front(), qa_tag.pop_front());
      end
      if (rst_n && b_ack) begin
         if (qb_exp.size() == 0) chk(1, 0, "R10 level ack with no request");
         else chk(b_rd, qb_exp.pop_front(), qb_tag.pop_front());
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(a_irq, 0, "R1 latched irq after reset");
      chk(b_irq, 0, "R1 level irq after reset");
      rd(0, 8'h00, 32'h0, "R1 latched status after reset");
      rd(0, 8'h0C, 32'hFFFF_FFFF, "R1 R4 latched mask after reset");
      rd(1, 8'h04, 32'hFFFF_FFFF, "R1 R4 level mask after reset");

      // R3, R2 mask clear and set
      wr(0, 8'h14, 32'h0000_00FF);
      rd(0, 8'h0C, 32'hFFFF_FF00, "R3 mask clear");
      wr(0, 8'h10, 32'h0000_000F);
      rd(0, 8'h0C, 32'hFFFF_FF0F, "R2 mask set keeps zero bits");

      // R11 writes to read-only and unmapped offsets
      wr(0, 8'h00, 32'hFFFF_FFFF);
      wr(0, 8'h0C, 32'h0000_0000);
      wr(0, 8'h04, 32'hFFFF_FFFF);
      wr(0, 8'h18, 32'h0000_0000);
      rd(0, 8'h0C, 32'hFFFF_FF0F, "R11 ignored writes latched");

      // R10 write-only and unmapped reads return zero
      rd(0, 8'h10, 32'h0, "R10 read mask-set");
      rd(0, 8'h14, 32'h0, "R10 read mask-clear");
      rd(0, 8'h08, 32'h0, "R10 read clear");
      rd(0, 8'h04, 32'h0, "R10 read unmapped 0x04");
      rd(0, 8'h1C, 32'h0, "R10 read unmapped 0x1C");

      // R5 sticky capture, R9 output
      src[4] = 1'b1; idle(5);
      chk(a_irq, 1, "R9 irq with unmasked pending");
      src[4] = 1'b0; idle(5);
      rd(0, 8'h00, 32'h0000_0010, "R5 sticky after source falls");
      chk(a_irq, 1, "R5 irq stays after source falls");
      // R8 masked source still visible
      src[20] = 1'b1; idle(5); src[20] = 1'b0; idle(2);
      rd(0, 8'h00, 32'h0010_0010, "R8 masked source in status");

      // R6 clear write with zero bits untouched
      wr(0, 8'h08, 32'h0000_0010);
      rd(0, 8'h00, 32'h0010_0000, "R6 clear only written bit");
      chk(a_irq, 0, "R9 only masked pending gives no irq");
      wr(0, 8'h14, 32'h0010_0000);
      chk(a_irq, 1, "R9 irq after unmask of pending");
      wr(0, 8'h08, 32'h0010_0000);
      chk(a_irq, 0, "R6 R9 irq low after clear");
      rd(0, 8'h00, 32'h0, "R6 status empty");

      // R6 edge in the same cycle as clear
      src[4] = 1'b1; idle(5); src[4] = 1'b0; idle(5);
      @(negedge clk); src[4] = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk); a_addr = 8'h08; a_wd = 32'h0000_0010; a_wv = 1'b1;
      @(negedge clk); a_wv = 1'b0;
      rd(0, 8'h00, 32'h0000_0010, "R6 edge wins over clear");
      wr(0, 8'h08, 32'h0000_0010);
      rd(0, 8'h00, 32'h0, "R5 R6 held level does not re-set");
      src[4] = 1'b0; idle(4);

      // R12 latency through synchronizer and capture
      @(negedge clk); src[7] = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk); chk(a_irq, 0, "R12 irq not before sync+1 edges");
      @(negedge clk); chk(a_irq, 1, "R12 irq at sync+1 edges");
      src[7] = 1'b0; idle(4);
      wr(0, 8'h08, 32'h0000_0080);
      rd(0, 8'h00, 32'h0, "R6 clear after latency test");

      // Level variant: R7
      wr(1, 8'h0C, 32'hFFFF_FFFF);
      rd(1, 8'h04, 32'h0, "R3 R4 level mask clear");
      src[3] = 1'b1; idle(5);
      rd(1, 8'h00, 32'h0000_0008, "R7 level status follows input");
      chk(b_irq, 1, "R9 level irq");
      wr(1, 8'h14, 32'hFFFF_FFFF);
      wr(1, 8'h10, 32'hFFFF_FFFF);
      rd(1, 8'h04, 32'h0, "R11 level unmapped writes ignored");
      rd(1, 8'h00, 32'h0000_0008, "R7 level status not clearable");
      rd(1, 8'h10, 32'h0, "R10 level unmapped read");
      src[3] = 1'b0; idle(5);
      rd(1, 8'h00, 32'h0, "R7 level status drops with input");
      chk(b_irq, 0, "R7 level irq drops");
      wr(1, 8'h08, 32'h0000_0008);
      rd(1, 8'h04, 32'h0000_0008, "R2 level mask set");
      src[3] = 1'b1; idle(5);
      chk(b_irq, 0, "R9 level masked no irq");
      rd(1, 8'h00, 32'h0000_0008, "R8 level masked still in status");
      src[3] = 1'b0;

      idle(4);
      chk(qa_exp.size(), 0, "R10 latched reads all answered");
      chk(qb_exp.size(), 0, "R10 level reads all answered");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule